// File: doc/BRIEF.md
# Serially Programmed Clock Fan-Out Gate

This block takes one input clock and hands it to eighteen output pins. Software or a board controller selects which of those pins carry the clock by sending a short write over a two-wire serial bus: a START condition, an address byte, up to three mask bytes, and then a STOP. A pin whose mask bit is set carries the input clock at its own frequency. A pin whose mask bit is clear is held at a steady low. A global enable input overrides the mask and releases every pin to high impedance.

The serial slave only accepts writes. It has a fixed 7-bit address of 1101001, and the data bits travel most significant bit first. SCL and SDA are oversampled in the input-clock domain. The slave acknowledges by asserting a pull-down request, which an open-drain pad cell outside the block turns into a low on SDA. Each output pin is brought out as a value and an enable, so the three-state pad cells can be placed at the chip boundary. After reset every output is enabled, so the clocks run before anything has been programmed.

Top module: `clk_fanout_gate`

## Requirements
- R1: After reset every mask bit is 1, so with `oe` high every `out_val` bit follows `buf_in`.
- R2: While `oe` is low, every `out_en` bit is 0 and every `out_val` bit is 0, whatever the mask holds.
- R3: While `oe` is high, every `out_en` bit is 1. `out_val[i]` equals `buf_in` when mask bit i is 1 and stays 0 when it is 0. A mask change reaches the pins only while `buf_in` is low.
- R4: An address byte of 0xD2 (address 1101001 followed by R/W = 0, sent MSB first) is acknowledged: `sda_pull_low` is 1 while SCL is high on the ninth clock.
- R5: When the address differs, or when R/W is 1, neither the address byte nor any byte after it is acknowledged. The mask stays unchanged until the next START.
- R6: Data bytes arrive MSB first. Bit k of the first data byte drives mask bit k, and bit k of the second data byte drives mask bit 8+k.
- R7: In the third data byte, bit 7 drives mask bit 17 and bit 6 drives mask bit 16. Bits 5 to 0 of that byte have no effect.
- R8: A data byte is committed when its eighth bit is received. A byte cut short by a STOP leaves its mask bits unchanged, while the bytes already completed in the same frame still apply.
- R9: The fourth and any later data bytes are acknowledged and have no effect on the mask.
- R10: Every START, including a repeated START with no STOP before it, makes the next data byte the first data byte again.
- R11: Inside a matched frame, each data byte is acknowledged on its ninth clock. The pull-down is released after the falling edge of SCL that ends that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| buf_in | input | 1 | Input clock that is distributed; it also samples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset; sets every mask bit to 1 |
| oe | input | 1 | Global output enable; low releases all outputs |
| scl | input | 1 | Serial bus clock |
| sda | input | 1 | Serial bus data, as seen on the wire |
| sda_pull_low | output | 1 | Acknowledge request; 1 asks the pad to pull SDA low |
| out_val | output | 18 | Value driven on each clock output pin |
| out_en | output | 18 | Drive enable of each clock output pin (0 = high impedance) |

## Verification
The hardest states to reach are the ones where a frame ends at an awkward point: a STOP in the middle of a byte, a repeated START after a completed byte, and a fifth byte after the third mask byte has already been taken. Each of these must leave the committed mask bytes intact while the partial or surplus ones are dropped. The bench drives the bus one bit at a time and has separate START and STOP tasks, so it can place either condition after any bit. It then reads the mask back through the output pins, checking both the high and the low phase of `buf_in`. The acknowledge window is sampled in the middle of the ninth SCL high phase, after the synchronizer latency has passed.

// File: rtl/clk_fanout_pkg.sv
`timescale 1ns/1ps
package clk_fanout_pkg;

  localparam int NUM_OUT     = 18;
  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = 7;
  localparam int MASK_BYTES  = 3;
  localparam int IDX_W       = $clog2(MASK_BYTES + 1);
  localparam int BITCNT_W    = $clog2(BYTE_W);
  localparam int SYNC_STAGES = 2;
  localparam logic [ADDR_W-1:0] DEV_ADDR = 7'b1101001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_IGNORE
  } ser_state_e;

  // The first byte of a frame selects this slave for writing.
  function automatic logic addr_selects(input logic [BYTE_W-1:0] first);
    return (first[BYTE_W-1:1] == DEV_ADDR) && (first[0] == 1'b0);
  endfunction

  // Fold one received byte into the mask. Slot 2 carries only two live bits.
  function automatic logic [NUM_OUT-1:0] fold_byte(
    input logic [NUM_OUT-1:0] cur,
    input logic [IDX_W-1:0]   slot,
    input logic [BYTE_W-1:0]  val
  );
    logic [NUM_OUT-1:0] nxt;
    nxt = cur;
    case (slot)
      2'd0:    nxt[7:0]   = val;
      2'd1:    nxt[15:8]  = val;
      2'd2:    nxt[17:16] = val[7:6];
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/ser_bus_sampler.sv
`timescale 1ns/1ps
module ser_bus_sampler #(
  parameter int STAGES = clk_fanout_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic              scl_q;
  logic              scl_d;
  logic              sda_d;

  // The idle bus is high on both lines.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[STAGES-2:0], sda_in};
      scl_d  <= scl_q;
      sda_d  <= sda_q;
    end
  end

  assign scl_q     = scl_sh[STAGES-1];
  assign sda_q     = sda_sh[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  // A change of SDA while SCL stays high marks a frame boundary.
  assign start_evt = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_evt  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/ser_write_slave.sv
`timescale 1ns/1ps
module ser_write_slave
  import clk_fanout_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  output logic              wr_stb,
  output logic [IDX_W-1:0]  wr_slot,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              ack_drive
);

  localparam logic [BITCNT_W-1:0] LAST_BIT  = BITCNT_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0]    SLOT_SINK = IDX_W'(MASK_BYTES);

  ser_state_e             state;
  logic [BITCNT_W-1:0]    bit_cnt;
  logic [BYTE_W-2:0]      shreg;
  logic [IDX_W-1:0]       slot;
  logic                   ack_due;
  logic [BYTE_W-1:0]      full_byte;
  logic                   byte_done;

  assign full_byte = {shreg, sda_q};
  assign byte_done = scl_rise && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      slot      <= '0;
      ack_due   <= 1'b0;
      ack_drive <= 1'b0;
      wr_stb    <= 1'b0;
      wr_slot   <= '0;
      wr_byte   <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_evt) begin
        state     <= ST_ADDR;
        bit_cnt   <= '0;
        slot      <= '0;
        ack_due   <= 1'b0;
        ack_drive <= 1'b0;
      end else if (stop_evt) begin
        state     <= ST_IDLE;
        ack_due   <= 1'b0;
        ack_drive <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg   <= full_byte[BYTE_W-2:0];
              bit_cnt <= bit_cnt + 1'b1;
            end
            if (byte_done) begin
              if (addr_selects(full_byte)) begin
                state   <= ST_ADDR_ACK;
                ack_due <= 1'b1;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_DATA: begin
            if (scl_rise) begin
              shreg   <= full_byte[BYTE_W-2:0];
              bit_cnt <= bit_cnt + 1'b1;
            end
            if (byte_done) begin
              wr_stb  <= 1'b1;
              wr_slot <= slot;
              wr_byte <= full_byte;
              if (slot != SLOT_SINK) slot <= slot + 1'b1;
              state   <= ST_DATA_ACK;
              ack_due <= 1'b1;
            end
          end
          ST_ADDR_ACK, ST_DATA_ACK: begin
            if (scl_fall) begin
              if (ack_due) begin
                ack_drive <= 1'b1;
                ack_due   <= 1'b0;
              end else if (ack_drive) begin
                ack_drive <= 1'b0;
                bit_cnt   <= '0;
                state     <= ST_DATA;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4, R11: the pull-down only ever starts inside an acknowledge slot
  a_r4_ack_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_drive) |-> (state == ST_ADDR_ACK || state == ST_DATA_ACK));

  // R11: the pull-down ends on an SCL fall or at a frame boundary
  a_r11_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_drive) |-> ($past(scl_fall) || $past(start_evt) || $past(stop_evt)));

  // R5: a frame that was not selected never acknowledges
  a_r5_ignored_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |=> !ack_drive);

  // R9: once past the last mask byte, the slot stays in the sink until a START
  a_r9_slot_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SLOT_SINK && !start_evt) |=> (slot == SLOT_SINK));

endmodule

// File: rtl/mask_bank.sv
`timescale 1ns/1ps
module mask_bank
  import clk_fanout_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [IDX_W-1:0]   wr_slot,
  input  logic [BYTE_W-1:0]  wr_byte,
  output logic [NUM_OUT-1:0] mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask <= '1;
    else if (wr_stb) mask <= fold_byte(mask, wr_slot, wr_byte);
  end

  // R8: the mask moves only when a complete byte is handed over
  a_r8_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(mask));

  // R6: the first byte lands on the low eight outputs
  a_r6_first_byte_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_slot == 2'd0) |=> (mask[7:0] == $past(wr_byte)));

  // R7: the third byte never disturbs outputs 15..0
  a_r7_third_byte_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_slot == 2'd2) |=> (mask[15:0] == $past(mask[15:0])));

  // R9: surplus bytes leave the mask untouched
  a_r9_surplus_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_slot == 2'd3) |=> $stable(mask));

endmodule

// File: rtl/clk_out_stage.sv
`timescale 1ns/1ps
module clk_out_stage
  import clk_fanout_pkg::*;
(
  input  logic               buf_in,
  input  logic               rst_n,
  input  logic               oe,
  input  logic [NUM_OUT-1:0] mask,
  output logic [NUM_OUT-1:0] out_val,
  output logic [NUM_OUT-1:0] out_en
);

  logic [NUM_OUT-1:0] gate_mask;

  // Retime on the falling edge so that a gate opens or closes only while the clock is low.
  always_ff @(negedge buf_in or negedge rst_n) begin
    if (!rst_n) gate_mask <= '1;
    else        gate_mask <= mask;
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_pin
    assign out_en[g]  = oe;
    assign out_val[g] = oe & gate_mask[g] & buf_in;
  end

  // R3: the gate copy has caught up with the mask by every rising edge
  a_r3_gate_tracks_mask: assert property (@(posedge buf_in) disable iff (!rst_n)
    gate_mask == mask);

endmodule

// File: rtl/clk_fanout_gate.sv
`timescale 1ns/1ps
module clk_fanout_gate
  import clk_fanout_pkg::*;
(
  input  logic               buf_in,
  input  logic               rst_n,
  input  logic               oe,
  input  logic               scl,
  input  logic               sda,
  output logic               sda_pull_low,
  output logic [NUM_OUT-1:0] out_val,
  output logic [NUM_OUT-1:0] out_en
);

  logic               sda_q;
  logic               scl_rise;
  logic               scl_fall;
  logic               start_evt;
  logic               stop_evt;
  logic               wr_stb;
  logic [IDX_W-1:0]   wr_slot;
  logic [BYTE_W-1:0]  wr_byte;
  logic [NUM_OUT-1:0] mask;

  ser_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk       (buf_in),
    .rst_n     (rst_n),
    .scl_in    (scl),
    .sda_in    (sda),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  ser_write_slave u_slave (
    .clk       (buf_in),
    .rst_n     (rst_n),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .wr_stb    (wr_stb),
    .wr_slot   (wr_slot),
    .wr_byte   (wr_byte),
    .ack_drive (sda_pull_low)
  );

  mask_bank u_mask (
    .clk     (buf_in),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_slot (wr_slot),
    .wr_byte (wr_byte),
    .mask    (mask)
  );

  clk_out_stage u_out (
    .buf_in  (buf_in),
    .rst_n   (rst_n),
    .oe      (oe),
    .mask    (mask),
    .out_val (out_val),
    .out_en  (out_en)
  );

endmodule

// File: tb/tb_clk_fanout_gate.sv
`timescale 1ns/1ps
module tb_clk_fanout_gate;

  logic        buf_in = 1'b0;
  logic        rst_n  = 1'b0;
  logic        oe     = 1'b1;
  logic        scl    = 1'b1;
  logic        m_sda  = 1'b1;
  wire         sda_line;
  logic        sda_pull_low;
  logic [17:0] out_val;
  logic [17:0] out_en;
  int          checks = 0;
  int          errors = 0;

  assign sda_line = m_sda & ~sda_pull_low;

  clk_fanout_gate dut (
    .buf_in       (buf_in),
    .rst_n        (rst_n),
    .oe           (oe),
    .scl          (scl),
    .sda          (sda_line),
    .sda_pull_low (sda_pull_low),
    .out_val      (out_val),
    .out_en       (out_en)
  );

  always #4 buf_in = ~buf_in;

  initial begin
    repeat (150000) @(posedge buf_in);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Mask images are rebuilt output by output here.
  function automatic logic [17:0] expect_mask(input logic [7:0] a, input logic [7:0] b,
                                              input logic [7:0] c);
    logic [17:0] m;
    for (int o = 0; o < 18; o++) begin
      if (o < 8)       m[o] = a[o];
      else if (o < 16) m[o] = b[o-8];
      else             m[o] = c[o-10];
    end
    return m;
  endfunction

  localparam logic [23:0] VEC [6] = '{
    24'hFFFFFF, 24'h000000, 24'hA55A80, 24'h018040, 24'h3CC33F, 24'hFF00C0
  };

  task automatic tick(input int n);
    repeat (n) @(negedge buf_in);
  endtask

  task automatic cmp(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cmp_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_pins(input string tag, input logic [17:0] m, input logic en);
    @(posedge buf_in); #2;
    cmp({tag, " high"}, out_val, en ? m : 18'h0);
    cmp({tag, " en"}, out_en, {18{en}});
    @(negedge buf_in); #2;
    cmp({tag, " low"}, out_val, 18'h0);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(5);
    scl = 1'b1;   tick(10);
    m_sda = 1'b0; tick(10);
    scl = 1'b0;   tick(5);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(5);
    scl = 1'b1;   tick(10);
    m_sda = 1'b1; tick(10);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; tick(5);
    scl = 1'b1; tick(10);
    scl = 1'b0; tick(5);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    m_sda = 1'b1; tick(5);
    scl = 1'b1;   tick(5);
    ack = sda_pull_low;
    tick(5);
    scl = 1'b0;   tick(5);
  endtask

  task automatic frame(input logic [7:0] adr, input int n, input logic [31:0] d,
                       output logic [4:0] acks);
    acks = '0;
    bus_start;
    send_byte(adr, acks[0]);
    for (int i = 0; i < n; i++) send_byte(d[31-8*i -: 8], acks[i+1]);
    bus_stop;
    tick(6);
  endtask

  initial begin
    logic [4:0]  acks;
    logic        a;
    logic [17:0] cur;

    tick(3);
    rst_n = 1'b1;
    tick(3);
    check_pins("R1 reset all enabled", 18'h3FFFF, 1'b1);

    // Table walk: each entry rewrites all three mask bytes.
    for (int v = 0; v < 6; v++) begin
      frame(8'hD2, 3, {VEC[v], 8'h00}, acks);
      cmp_bit("R4 address ack", acks[0], 1'b1);
      cmp({"R11 data acks"}, {15'h0, acks[3:1]}, 18'h7);
      cur = expect_mask(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
      check_pins("R3 R6 R7 table mask", cur, 1'b1);
    end

    oe = 1'b0; tick(2);
    check_pins("R2 oe low releases all", cur, 1'b0);
    oe = 1'b1; tick(2);
    check_pins("R3 oe restored", cur, 1'b1);

    frame(8'h90, 3, 32'h00000000, acks);
    cmp({"R5 wrong address no ack"}, {13'h0, acks}, 18'h0);
    check_pins("R5 wrong address mask kept", cur, 1'b1);

    frame(8'hD3, 3, 32'h00000000, acks);
    cmp({"R5 read bit no ack"}, {13'h0, acks}, 18'h0);
    check_pins("R5 read bit mask kept", cur, 1'b1);

    // R8: second byte cut after five ones by a STOP.
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_stop;
    tick(6);
    cur = expect_mask(8'h00, 8'h00, 8'hC0);
    check_pins("R8 partial byte dropped", cur, 1'b1);

    frame(8'hD2, 4, 32'h1234C000, acks);
    cmp_bit("R9 fourth byte acked", acks[4], 1'b1);
    cur = expect_mask(8'h12, 8'h34, 8'hC0);
    check_pins("R9 fourth byte no effect", cur, 1'b1);

    // R10: a repeated START sends the next byte back to slot zero.
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h0F, a);
    bus_start;
    send_byte(8'hD2, a);
    cmp_bit("R10 ack after repeated start", a, 1'b1);
    send_byte(8'hF0, a);
    bus_stop;
    tick(6);
    cur = expect_mask(8'hF0, 8'h34, 8'hC0);
    check_pins("R10 restart at first byte", cur, 1'b1);

    frame(8'hD2, 3, 32'hFFFF3F00, acks);
    cur = expect_mask(8'hFF, 8'hFF, 8'h3F);
    check_pins("R7 reserved bits ignored", cur, 1'b1);

    rst_n = 1'b0; tick(3);
    rst_n = 1'b1; tick(3);
    check_pins("R1 reset restores all", 18'h3FFFF, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule